// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a compact processor that completes one instruction on every rising clock edge. The program counter addresses a 256-word instruction ROM whose contents are fixed by a parameter at elaboration. The fetched word is split into fields, and the 6-bit operation code is decoded. In the same cycle the core then writes the destination register and steps or redirects the program counter. Data memory sits outside the core: loads and stores show up as single-cycle read and write strobes, with the address, the write data and the returned read data all on plain buses.

The register file holds 32 entries of 32 bits. The two 16-bit halves of an entry are written independently, so a pair of immediate loads (one per half) builds any 32-bit constant. Arithmetic, logic and shift results go to the destination register. Conditional branches test the sign and zero status of their first source register in the same cycle. Relative branches add an unsigned 26-bit offset to the word-counting program counter. The ROM is indexed by the low 8 bits of the program counter, so any offset wraps inside the ROM.

Top module: `sc32_core`

## Requirements
- R1: While `rst_n` is low the program counter is 0, and it drops to 0 at once when `rst_n` falls, without waiting for a clock edge. Both strobes stay low and no register is written. After `rst_n` rises the core waits two rising edges, and the first instruction (at address 0) takes effect on the third.
- R2: Each cycle the instruction is ROM word `pc_o[7:0]`. Its fields are: opcode in bits 31:26, destination in 25:21, first source in 20:16, second source in 15:11, 16-bit immediate in 15:0 and 26-bit offset in 25:0. `bus_rd` is high only for opcode 17 and `bus_wr` only for opcode 18.
- R3: Every instruction that does not redirect control advances the program counter by exactly 1.
- R4: Opcodes 0 to 4 write rs1+rs2, rs1-rs2, the low 32 bits of rs1*rs2, rs1&rs2 and rs1|rs2 into both halves of the destination.
- R5: Opcode 5 writes ~rs1. Opcode 6 writes rs1 shifted left by the unsigned value of rs2. Opcode 7 writes rs1 shifted right logically by rs2. A shift amount of 32 or more gives 0.
- R6: Opcode 8 copies rs1 into the destination.
- R7: Opcode 15 writes the immediate into bits 31:16 of the destination and opcode 16 writes it into bits 15:0. The other half is left unchanged.
- R8: Opcode 17 raises `bus_rd`, drives rs1 on `bus_addr` and writes `bus_rdata` into the destination on the same edge.
- R9: Opcode 18 raises `bus_wr` for one cycle, with rs1 on `bus_addr` and rs2 on `bus_wdata`. It writes no register.
- R10: Opcode 10 sets the program counter to its value plus the zero-extended 26-bit offset.
- R11: Opcodes 11, 12, 13 and 14 take the relative jump of R10 when rs1 is zero, non-zero, negative or positive respectively, with rs1 read as signed. Otherwise they advance by 1. None writes a register.
- R12: Opcode 9 loads the program counter with rs1 and writes no register.
- R13: Opcodes 19 to 63 advance the program counter by 1, raise no strobe and leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_o | output | 32 | Current program counter (word address) |
| bus_addr | output | 32 | Data bus address (first source register) |
| bus_wdata | output | 32 | Data bus write data (second source register) |
| bus_rdata | input | 32 | Data bus read data, sampled on the edge ending a load |
| bus_rd | output | 1 | Load strobe |
| bus_wr | output | 1 | Store strobe |

## Verification
The bench goes after these corner cases:

- **Half-word loads.** A core that wrote both halves on a half-word load would corrupt the other half of a register holding random data.
- **Shift amounts.** A design that used only the low five bits of the shift amount would return a non-zero result for shifts of 32 or more.
- **Branch conditions.** A branch on zero, on all ones or on the most negative value exposes an unsigned compare or an inverted condition through the program-counter trace.
- **Long offsets.** Offsets with high bits set show whether the full 26-bit offset is added to the whole 32-bit counter.
- **Undefined opcodes.** Undefined opcodes are placed before stores of the register they name, so a stray write shows up on `bus_wdata`.

// File: rtl/sc32_pkg.sv
`timescale 1ns/1ps
package sc32_pkg;
  localparam int XLEN      = 32;
  localparam int HALFW     = XLEN / 2;
  localparam int NREG      = 32;
  localparam int RIDX      = $clog2(NREG);
  localparam int OPW       = 6;
  localparam int OFFW      = 26;
  localparam int ROM_WORDS = 256;
  localparam int ROM_AW    = $clog2(ROM_WORDS);
  localparam int OPC_LSB   = XLEN - OPW;
  localparam int RD_LSB    = OPC_LSB - RIDX;
  localparam int RS1_LSB   = RD_LSB - RIDX;
  localparam int RS2_LSB   = RS1_LSB - RIDX;

  typedef enum logic [OPW-1:0] {
    OPC_ADD = 6'd0,  OPC_SUB = 6'd1,  OPC_MUL = 6'd2,  OPC_AND = 6'd3,
    OPC_OR  = 6'd4,  OPC_NOT = 6'd5,  OPC_SL  = 6'd6,  OPC_SR  = 6'd7,
    OPC_MOV = 6'd8,  OPC_JR  = 6'd9,  OPC_J   = 6'd10, OPC_JE  = 6'd11,
    OPC_JNE = 6'd12, OPC_JL  = 6'd13, OPC_JG  = 6'd14, OPC_LH  = 6'd15,
    OPC_LL  = 6'd16, OPC_LW  = 6'd17, OPC_SW  = 6'd18
  } opcode_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_MUL, ALU_AND, ALU_OR, ALU_NOT, ALU_SHR, ALU_SHL, ALU_PASS
  } alu_op_e;

  typedef enum logic [1:0] { PC_STEP, PC_REL, PC_ABS } pc_mode_e;
  typedef enum logic [1:0] { WSRC_IMM, WSRC_ALU, WSRC_BUS } wsrc_e;

  typedef struct packed {
    wsrc_e   wsrc;
    alu_op_e alu_op;
    logic    mem_rd;
    logic    mem_wr;
    logic    wr_hi;
    logic    wr_lo;
  } ctrl_t;

  typedef struct packed {
    logic [OPW-1:0]   opc;
    logic [RIDX-1:0]  rd;
    logic [RIDX-1:0]  rs1;
    logic [RIDX-1:0]  rs2;
    logic [HALFW-1:0] imm;
    logic [OFFW-1:0]  off;
  } fields_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic zero;
  } flags_t;

  function automatic logic [ROM_WORDS*XLEN-1:0] fill_pattern();
    logic [ROM_WORDS*XLEN-1:0] img;
    img = '0;
    for (int i = 0; i < ROM_WORDS; i++) begin
      img[i*XLEN +: XLEN] = {4{i[7:0]}};
    end
    return img;
  endfunction
endpackage

// File: rtl/sc32_irom.sv
`timescale 1ns/1ps
module sc32_irom #(
  parameter int WORDS = 256,
  parameter int XLEN  = 32,
  parameter logic [WORDS*XLEN-1:0] IMAGE = '0,
  localparam int AW = $clog2(WORDS)
) (
  input  logic [AW-1:0]   addr,
  output logic [XLEN-1:0] word
);
  logic [XLEN-1:0] rom [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign rom[i] = IMAGE[i*XLEN +: XLEN];
  end

  assign word = rom[addr];
endmodule

// File: rtl/sc32_decode.sv
`timescale 1ns/1ps
module sc32_decode import sc32_pkg::*; (
  input  logic [XLEN-1:0] instr,
  input  flags_t          flags,
  output fields_t         fld,
  output ctrl_t           ctl,
  output pc_mode_e        pc_mode
);
  assign fld.opc = instr[OPC_LSB +: OPW];
  assign fld.rd  = instr[RD_LSB  +: RIDX];
  assign fld.rs1 = instr[RS1_LSB +: RIDX];
  assign fld.rs2 = instr[RS2_LSB +: RIDX];
  assign fld.imm = instr[HALFW-1:0];
  assign fld.off = instr[OFFW-1:0];

  // Static control: independent of the flags so no loop forms through the ALU.
  always_comb begin
    ctl.wsrc   = WSRC_ALU;
    ctl.alu_op = ALU_PASS;
    ctl.mem_rd = 1'b0;
    ctl.mem_wr = 1'b0;
    ctl.wr_hi  = 1'b0;
    ctl.wr_lo  = 1'b0;
    case (fld.opc)
      OPC_ADD: begin ctl.alu_op = ALU_ADD; ctl.wr_hi = 1'b1; ctl.wr_lo = 1'b1; end
      OPC_SUB: begin ctl.alu_op = ALU_SUB; ctl.wr_hi = 1'b1; ctl.wr_lo = 1'b1; end
      OPC_MUL: begin ctl.alu_op = ALU_MUL; ctl.wr_hi = 1'b1; ctl.wr_lo = 1'b1; end
      OPC_AND: begin ctl.alu_op = ALU_AND; ctl.wr_hi = 1'b1; ctl.wr_lo = 1'b1; end
      OPC_OR:  begin ctl.alu_op = ALU_OR;  ctl.wr_hi = 1'b1; ctl.wr_lo = 1'b1; end
      OPC_NOT: begin ctl.alu_op = ALU_NOT; ctl.wr_hi = 1'b1; ctl.wr_lo = 1'b1; end
      OPC_SL:  begin ctl.alu_op = ALU_SHL; ctl.wr_hi = 1'b1; ctl.wr_lo = 1'b1; end
      OPC_SR:  begin ctl.alu_op = ALU_SHR; ctl.wr_hi = 1'b1; ctl.wr_lo = 1'b1; end
      OPC_MOV: begin ctl.wr_hi = 1'b1; ctl.wr_lo = 1'b1; end
      OPC_LH:  begin ctl.wsrc = WSRC_IMM; ctl.wr_hi = 1'b1; end
      OPC_LL:  begin ctl.wsrc = WSRC_IMM; ctl.wr_lo = 1'b1; end
      OPC_LW:  begin ctl.wsrc = WSRC_BUS; ctl.mem_rd = 1'b1; ctl.wr_hi = 1'b1; ctl.wr_lo = 1'b1; end
      OPC_SW:  begin ctl.mem_wr = 1'b1; end
      default: ;
    endcase
  end

  // Program-counter control: conditional forms look at the flags of rs1.
  always_comb begin
    pc_mode = PC_STEP;
    case (fld.opc)
      OPC_JR:  pc_mode = PC_ABS;
      OPC_J:   pc_mode = PC_REL;
      OPC_JE:  if (flags.zero)  pc_mode = PC_REL;
      OPC_JNE: if (!flags.zero) pc_mode = PC_REL;
      OPC_JL:  if (flags.lt)    pc_mode = PC_REL;
      OPC_JG:  if (flags.gt)    pc_mode = PC_REL;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc32_regfile.sv
`timescale 1ns/1ps
module sc32_regfile #(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  parameter int NSEG = 2,
  localparam int AW   = $clog2(NREG),
  localparam int SEGW = XLEN / NSEG
) (
  input  logic            clk,
  input  logic [NSEG-1:0] we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEGW-1:0] bank [NREG];

    always_ff @(posedge clk) begin
      if (we[s]) begin
        bank[waddr] <= wdata[s*SEGW +: SEGW];
      end
    end

    assign rdata_a[s*SEGW +: SEGW] = bank[raddr_a];
    assign rdata_b[s*SEGW +: SEGW] = bank[raddr_b];
  end
endmodule

// File: rtl/sc32_alu.sv
`timescale 1ns/1ps
module sc32_alu import sc32_pkg::*; (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output flags_t          flags
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_MUL: y = a * b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOT: y = ~a;
      ALU_SHR: y = a >> b;
      ALU_SHL: y = a << b;
      default: y = a;
    endcase
  end

  assign flags.zero = (y == '0);
  assign flags.lt   = y[XLEN-1];
  assign flags.gt   = !y[XLEN-1] && (y != '0);
endmodule

// File: rtl/sc32_core.sv
`timescale 1ns/1ps
module sc32_core import sc32_pkg::*; #(
  parameter logic [ROM_WORDS*XLEN-1:0] ROM_IMAGE = fill_pattern()
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] bus_addr,
  output logic [XLEN-1:0] bus_wdata,
  input  logic [XLEN-1:0] bus_rdata,
  output logic            bus_rd,
  output logic            bus_wr
);
  localparam int NSEG = 2;

  logic [1:0]      sync_q;
  logic            run;
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] instr;
  logic [XLEN-1:0] rs1_data, rs2_data, alu_y, wb_data;
  logic [NSEG-1:0] we;
  fields_t         fld;
  ctrl_t           ctl;
  pc_mode_e        pc_mode;
  flags_t          flags;

  // Reset: asserted asynchronously, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign run = sync_q[1];

  sc32_irom #(.WORDS(ROM_WORDS), .XLEN(XLEN), .IMAGE(ROM_IMAGE)) u_irom (
    .addr (pc_q[ROM_AW-1:0]),
    .word (instr)
  );

  sc32_decode u_decode (
    .instr   (instr),
    .flags   (flags),
    .fld     (fld),
    .ctl     (ctl),
    .pc_mode (pc_mode)
  );

  sc32_regfile #(.NREG(NREG), .XLEN(XLEN), .NSEG(NSEG)) u_regfile (
    .clk     (clk),
    .we      (we),
    .waddr   (fld.rd),
    .wdata   (wb_data),
    .raddr_a (fld.rs1),
    .raddr_b (fld.rs2),
    .rdata_a (rs1_data),
    .rdata_b (rs2_data)
  );

  sc32_alu u_alu (
    .a     (rs1_data),
    .b     (rs2_data),
    .op    (ctl.alu_op),
    .y     (alu_y),
    .flags (flags)
  );

  always_comb begin
    case (ctl.wsrc)
      WSRC_IMM: wb_data = {fld.imm, fld.imm};
      WSRC_BUS: wb_data = bus_rdata;
      default:  wb_data = alu_y;
    endcase
  end

  assign we = {ctl.wr_hi, ctl.wr_lo} & {NSEG{run}};

  always_comb begin
    case (pc_mode)
      PC_REL:  pc_d = pc_q + {{(XLEN-OFFW){1'b0}}, fld.off};
      PC_ABS:  pc_d = rs1_data;
      default: pc_d = pc_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (run) pc_q <= pc_d;
  end

  assign pc_o      = pc_q;
  assign bus_addr  = rs1_data;
  assign bus_wdata = rs2_data;
  assign bus_rd    = ctl.mem_rd & run;
  assign bus_wr    = ctl.mem_wr & run;

  a_r1_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pc_q == '0));

  a_r3_step_one: assert property (@(posedge clk) disable iff (!run)
    (pc_mode == PC_STEP) |=> (pc_q == $past(pc_q) + 1'b1));

  a_r12_abs_load: assert property (@(posedge clk) disable iff (!run)
    (pc_mode == PC_ABS) |=> (pc_q == $past(rs1_data)));

  a_r11_one_flag: assert property (@(posedge clk) disable iff (!run)
    $countones(flags) == 1);

  a_r13_undef_quiet: assert property (@(posedge clk) disable iff (!run)
    (fld.opc > 6'd18) |-> (we == '0 && !bus_rd && !bus_wr && pc_mode == PC_STEP));
endmodule

// File: tb/sc32_core_bench.sv
`timescale 1ns/1ps
module sc32_core_bench;
  localparam int W = 32;
  localparam int NW = 256;
  localparam int O_ADD = 0, O_SUB = 1, O_MUL = 2, O_AND = 3, O_OR = 4, O_NOT = 5;
  localparam int O_SL = 6, O_SR = 7, O_MOV = 8, O_JR = 9, O_J = 10, O_JE = 11;
  localparam int O_JNE = 12, O_JL = 13, O_JG = 14, O_LH = 15, O_LL = 16;
  localparam int O_LW = 17, O_SW = 18;

  function automatic logic [31:0] f_r(int op, int rd, int a, int b);
    return {op[5:0], rd[4:0], a[4:0], b[4:0], 11'd0};
  endfunction
  function automatic logic [31:0] f_i(int op, int rd, int imm);
    return {op[5:0], rd[4:0], 5'd0, imm[15:0]};
  endfunction
  function automatic logic [31:0] f_c(int op, int a, int off);
    return {op[5:0], 5'd0, a[4:0], off[15:0]};
  endfunction
  function automatic logic [31:0] f_j(int op, int off);
    return {op[5:0], off[25:0]};
  endfunction

  function automatic logic [31:0] prog(int a);
    case (a)
      0:  return f_i(O_LL, 0, 0);
      1:  return f_i(O_LH, 0, 0);
      2:  return f_r(O_LW, 1, 0, 0);
      3:  return f_r(O_LW, 2, 0, 0);
      4:  return f_r(O_LW, 3, 0, 0);
      5:  return f_r(O_ADD, 4, 1, 2);
      6:  return f_r(O_SW, 0, 1, 4);
      7:  return f_r(O_SUB, 5, 1, 2);
      8:  return f_r(O_SW, 0, 2, 5);
      9:  return f_r(O_MUL, 6, 1, 2);
      10: return f_r(O_SW, 0, 0, 6);
      11: return f_r(O_AND, 7, 1, 3);
      12: return f_r(O_SW, 0, 0, 7);
      13: return f_r(O_OR, 8, 2, 3);
      14: return f_r(O_SW, 0, 0, 8);
      15: return f_r(O_NOT, 9, 1, 0);
      16: return f_r(O_SW, 0, 0, 9);
      17: return f_i(O_LL, 10, 5);
      18: return f_i(O_LH, 10, 0);
      19: return f_r(O_SL, 11, 1, 10);
      20: return f_r(O_SW, 0, 0, 11);
      21: return f_r(O_SR, 12, 1, 10);
      22: return f_r(O_SW, 0, 0, 12);
      23: return f_r(O_SL, 13, 1, 3);
      24: return f_r(O_SW, 0, 0, 13);
      25: return f_r(O_SR, 14, 2, 3);
      26: return f_r(O_SW, 0, 0, 14);
      27: return f_i(O_LH, 1, 16'hBEEF);
      28: return f_r(O_SW, 0, 0, 1);
      29: return f_i(O_LL, 2, 16'h00C3);
      30: return f_r(O_SW, 0, 0, 2);
      31: return f_r(O_MOV, 16, 3, 0);
      32: return f_r(O_SW, 0, 16, 16);
      33: return f_r(19, 16, 1, 2);
      34: return f_r(O_SW, 0, 0, 16);
      35: return f_r(63, 3, 1, 2);
      36: return f_r(O_SW, 0, 0, 3);
      37: return f_r(O_SUB, 17, 3, 3);
      38: return f_c(O_JE, 17, 2);
      39: return f_r(O_SW, 0, 0, 0);
      40: return f_c(O_JNE, 17, 3);
      41: return f_c(O_JNE, 3, 2);
      42: return f_r(O_ADD, 18, 1, 2);
      43: return f_c(O_JL, 3, 2);
      44: return f_r(O_SW, 0, 0, 3);
      45: return f_c(O_JG, 3, 2);
      46: return f_r(O_ADD, 18, 1, 2);
      47: return f_c(O_JL, 17, 5);
      48: return f_c(O_JG, 17, 5);
      49: return f_i(O_LL, 18, 16'hFFFF);
      50: return f_i(O_LH, 18, 16'hFFFF);
      51: return f_c(O_JL, 18, 2);
      52: return f_r(O_ADD, 18, 1, 2);
      53: return f_c(O_JG, 18, 9);
      54: return f_j(O_J, 26'h3ABC02);
      55: return f_r(O_SW, 0, 0, 0);
      56: return f_i(O_LL, 19, 60);
      57: return f_i(O_LH, 19, 0);
      58: return f_r(O_JR, 0, 19, 0);
      59: return f_r(O_SW, 0, 0, 0);
      60: return f_r(O_JR, 0, 0, 0);
      default: return {6'h3F, 26'd0};
    endcase
  endfunction

  function automatic logic [NW*W-1:0] build_image();
    logic [NW*W-1:0] img;
    img = '0;
    for (int i = 0; i < NW; i++) img[i*W +: W] = prog(i);
    return img;
  endfunction

  localparam logic [NW*W-1:0] IMAGE = build_image();

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pc_o, bus_addr, bus_wdata, bus_rdata;
  logic        bus_rd, bus_wr;

  always #2.5 clk = ~clk;

  sc32_core #(.ROM_IMAGE(IMAGE)) u_sc32_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_o      (pc_o),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr)
  );

  int          n_chk = 0;
  int          n_err = 0;
  logic [31:0] m_reg [32];
  string       m_tag [32];
  logic [31:0] m_pc;
  string       pc_tag;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h (pc model %h)", tag, what, act, exp, m_pc);
    end
  endtask

  function automatic logic [31:0] alu_ref(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      O_ADD: return a + b;
      O_SUB: return a - b;
      O_MUL: return a * b;
      O_AND: return a & b;
      O_OR:  return a | b;
      O_NOT: return ~a;
      O_SL:  return (b > 31) ? 32'd0 : (a << b[4:0]);
      O_SR:  return (b > 31) ? 32'd0 : (a >> b[4:0]);
      default: return a;
    endcase
  endfunction

  function automatic logic [31:0] pick_data();
    case ($urandom % 8)
      0: return 32'd0;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return $urandom % 40;
      4: return 32'd1;
      default: return $urandom;
    endcase
  endfunction

  task automatic compare();
    logic [31:0] ins;
    int op, a, b;
    string stag;
    ins = prog(int'(m_pc[7:0]));
    op = int'(ins[31:26]); a = int'(ins[20:16]); b = int'(ins[15:11]);
    stag = (op == O_LW) ? "R8" : (op == O_SW) ? "R9" : (op > O_SW) ? "R13" : "R2";
    chk(pc_tag, "pc", pc_o, m_pc);
    chk(stag, "bus_rd", {31'd0, bus_rd}, {31'd0, op == O_LW});
    chk(stag, "bus_wr", {31'd0, bus_wr}, {31'd0, op == O_SW});
    if (op == O_LW) chk("R8", "load address", bus_addr, m_reg[a]);
    if (op == O_SW) begin
      chk("R9", "store address", bus_addr, m_reg[a]);
      chk(m_tag[b], "store data", bus_wdata, m_reg[b]);
    end
  endtask

  task automatic model_step(logic [31:0] rdat);
    logic [31:0] ins, av, bv, off, nxt;
    int op, rd, a, b;
    logic take;
    ins = prog(int'(m_pc[7:0]));
    op = int'(ins[31:26]); rd = int'(ins[25:21]); a = int'(ins[20:16]); b = int'(ins[15:11]);
    av = m_reg[a]; bv = m_reg[b];
    off = {6'd0, ins[25:0]};
    nxt = m_pc + 1;
    pc_tag = "R3";
    take = 1'b0;
    case (op)
      O_ADD, O_SUB, O_MUL, O_AND, O_OR: begin
        m_reg[rd] = alu_ref(op, av, bv); m_tag[rd] = "R4";
      end
      O_NOT, O_SL, O_SR: begin
        m_reg[rd] = alu_ref(op, av, bv); m_tag[rd] = "R5";
      end
      O_MOV: begin m_reg[rd] = av; m_tag[rd] = "R6"; end
      O_JR:  begin nxt = av; pc_tag = "R12"; end
      O_J:   begin nxt = m_pc + off; pc_tag = "R10"; end
      O_JE, O_JNE, O_JL, O_JG: begin
        case (op)
          O_JE:    take = (av == 0);
          O_JNE:   take = (av != 0);
          O_JL:    take = av[31];
          default: take = !av[31] && (av != 0);
        endcase
        if (take) nxt = m_pc + off;
        pc_tag = "R11";
      end
      O_LH: begin m_reg[rd][31:16] = ins[15:0]; m_tag[rd] = "R7"; end
      O_LL: begin m_reg[rd][15:0]  = ins[15:0]; m_tag[rd] = "R7"; end
      O_LW: begin m_reg[rd] = rdat; m_tag[rd] = "R8"; end
      O_SW: ;
      default: begin m_tag[rd] = "R13"; pc_tag = "R13"; end
    endcase
    m_pc = nxt;
  endtask

  task automatic check_in_reset();
    chk("R1", "pc in reset", pc_o, 32'd0);
    chk("R1", "bus_rd in reset", {31'd0, bus_rd}, 32'd0);
    chk("R1", "bus_wr in reset", {31'd0, bus_wr}, 32'd0);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check_in_reset();
    @(negedge clk);
    m_pc = 32'd0;
    pc_tag = "R1";
  endtask

  initial begin
    #250000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_reg[i] = 32'd0;
      m_tag[i] = "R2";
    end
    rst_n = 1'b1;
    bus_rdata = $urandom(32'd4711);
    #1 rst_n = 1'b0;
    #0.5;
    check_in_reset();
    repeat (3) @(negedge clk);
    check_in_reset();
    release_reset();
    for (int cyc = 0; cyc < 2400; cyc++) begin
      if (cyc == 1300) begin
        rst_n = 1'b0;
        #1;
        check_in_reset();
        repeat (3) @(negedge clk);
        check_in_reset();
        release_reset();
      end
      compare();
      bus_rdata = pick_data();
      model_step(bus_rdata);
      @(negedge clk);
    end
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule